// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block sequences single-processor bus cycles for a 16-bit core with a 20-bit address space. A request carries a direction (read or write), an address, write data, a transfer size (byte or word), a memory-or-I/O selector and a 2-bit segment code. The block runs one bus cycle of four clock states, T1 to T4. It drives a time-shared address/data bus, an address latch strobe, read and write strobes, a memory/IO select, a data enable and a direction line. The bus uses two byte lanes, chosen by the active-low high-byte enable together with address bit 0.

In T1 the shared lines carry the low 16 address bits and the four upper lines carry the high address nibble. From T2 on, the upper lines carry status bits and the high-byte enable is driven high. Read data is taken from the bus at the end of T3 and lined up to bit 0. A word request to an odd address does not start a bus cycle: it is refused with a one-cycle error pulse. A new request can be taken in T4, so bus cycles can follow one another with no idle clock between them.

Top module: `mux_bus_cycle_ctrl`

## Requirements
- R1: `ale` is high in T1 only. While it is high, `ad_oe` is 1, `ad_o` equals address bits 15..0 and `as_o` equals address bits 19..16.
- R2: In T2, T3 and T4, `as_o` carries status {S6,S5,S4,S3} = {0,0,seg[1],seg[0]} and `bhe_n` (status S7) is 1.
- R3: In T1, {`bhe_n`,`ad_o[0]`} is 00 for a word, 01 for a byte at an odd address and 10 for a byte at an even address.
- R4: A word request with address bit 0 set is refused. `err` is 1 for exactly the cycle after the request, and no `ale`, strobe or `done` follows.
- R5: `rd_n` is low in T2 and T3 of a read. `wr_n` is low in T2 and T3 of a write. The two are never low together.
- R6: `dt_r` (1 = transmit) is 1 from T1 through T4 of a write and 0 otherwise. `den_n` is low in T2 and T3 only, and `dt_r` does not change while `den_n` is low.
- R7: `m_io` equals the request's memory flag (1 = memory) from T1 through T4, and is 0 when no cycle is running.
- R8: During T2 and T3 of a write, `ad_oe` is 1 and `ad_o` carries the write data. A word drives all 16 bits; a byte puts `wdata[7:0]` on both lanes. `ad_oe` is 0 in T2 to T4 of a read and in T4 of a write.
- R9: `rdata` is loaded from `ad_i` at the end of T3 of a read. A word returns all 16 bits; a byte returns the even lane (bits 7..0) or the odd lane (bits 15..8) in bits 7..0, with the upper byte zero. The value holds until the next read.
- R10: `done` is 1 in T4 only. `ready` is 1 in idle and in T4. A request taken in T4 starts T1 on the next clock.
- R11: A request presented while `ready` is 0 is ignored and does not change the running cycle.
- R12: After reset: `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `dt_r`=`m_io`=`ad_oe`=0, `ready`=1, `done`=`err`=0, `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_seg | input | 2 | Segment code put into status S4:S3 |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | A request can be taken this cycle |
| done | output | 1 | Bus cycle in T4 |
| err | output | 1 | Misaligned word request refused |
| rdata | output | 16 | Read data, aligned to bit 0 |
| ad_o | output | 16 | Shared address/data bus, outgoing |
| ad_oe | output | 1 | Drive enable for ad_o |
| ad_i | input | 16 | Shared address/data bus, incoming |
| as_o | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch enable |
| bhe_n | output | 1 | High-byte enable, active low (S7 after T1) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| den_n | output | 1 | Data enable, active low |
| dt_r | output | 1 | Direction, 1 = transmit, 0 = receive |

## Verification
Two events can fall in the same cycle: the `done` pulse of one bus cycle and the taking of the next request, because T4 counts as ready. The bench runs a read and, in its T4, presents a write. In that one cycle it checks `done`, `ready` and the read data just captured. On the next clock it checks that `ale` rises with the new address, and that the write strobes, lane data and direction follow with no idle state in between. A misaligned word request is also presented in T4, to confirm that the refusal drops the block to idle and raises `err` with no latch strobe.

// File: rtl/bcc_pkg.sv
// Package bcc_pkg
// Shared types for the bus cycle controller: the clock-state encoding of
// one bus cycle, plus a helper that marks the states with strobes active.
package bcc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } bus_phase_t;

    // True in the two states where strobes and data enable are asserted.
    function automatic logic strobe_phase(input bus_phase_t p);
        return (p == PH_T2) || (p == PH_T3);
    endfunction

endpackage

// File: rtl/bcc_lane_map.sv
// Module bcc_lane_map
// Works out byte-lane selection for an incoming request. It gives the
// high-byte enable level, flags a word at an odd address, and places write
// data on the lanes (a byte is copied onto every lane).
// Assumes: DW is a multiple of 8; address bit 0 selects the lane of a byte.
module bcc_lane_map #(
    parameter int DW = 16
) (
    input  logic          word,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    output logic          misalign,
    output logic          bhe_n,
    output logic [DW-1:0] wlane
);
    localparam int LANES = DW / 8;

    // Lane selection: word -> both lanes; byte -> the lane picked by a0.
    always_comb begin
        misalign = word & a0;
        bhe_n    = ~(word | a0);
    end

    // Lane data: a word passes through, a byte is copied onto each lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wlane[g*8 +: 8] = word ? wdata[g*8 +: 8] : wdata[7:0];
    end

endmodule

// File: rtl/bcc_phase_seq.sv
// Module bcc_phase_seq
// Steps through the clock states of a bus cycle (T1..T4). It takes a
// request in idle or T4, refuses misaligned requests with a one-cycle
// error, and flags done in T4.
// Assumes: req_misalign is valid whenever req_valid is high.
module bcc_phase_seq
    import bcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_misalign,
    output bus_phase_t phase,
    output logic       accept,
    output logic       ready,
    output logic       done,
    output logic       err
);
    bus_phase_t phase_nx;
    logic       reject;

    // Handshake decode: ready in idle or T4, split into take or refuse.
    always_comb begin
        ready  = (phase == PH_IDLE) || (phase == PH_T4);
        accept = ready && req_valid && !req_misalign;
        reject = ready && req_valid && req_misalign;
        done   = (phase == PH_T4);
    end

    // Next-state: a fixed T1..T4 walk; T4 loops to T1 on a new request.
    always_comb begin
        case (phase)
            PH_IDLE: phase_nx = accept ? PH_T1 : PH_IDLE;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3:   phase_nx = PH_T4;
            PH_T4:   phase_nx = accept ? PH_T1 : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // State and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            err   <= 1'b0;
        end else begin
            phase <= phase_nx;
            err   <= reject;
        end
    end

    // R4: a refusal leaves the block idle, so no cycle runs with err.
    p_err_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (phase == PH_IDLE));

    // R10: done lasts a single cycle.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: once past T1 a cycle cannot be restarted by a new request.
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2) |=> (phase == PH_T3));

endmodule

// File: rtl/bcc_pin_drv.sv
// Module bcc_pin_drv
// Drives the bus pins from the current clock state and the stored request.
// It also captures and aligns read data at the end of T3.
// Assumes: the request fields stay unchanged from T1 through T4.
module bcc_pin_drv
    import bcc_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_phase_t    phase,
    input  logic          q_wr,
    input  logic          q_word,
    input  logic          q_mem,
    input  logic [1:0]    q_seg,
    input  logic [AW-1:0] q_addr,
    input  logic          q_bhe_n,
    input  logic [DW-1:0] q_wlane,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    output logic [AW-DW-1:0] as_o,
    output logic          ale,
    output logic          bhe_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          m_io,
    output logic          den_n,
    output logic          dt_r,
    output logic [DW-1:0] rdata
);
    localparam int AHI = AW - DW;

    logic          in_cycle;
    logic          strobe;
    logic [AHI-1:0] status;
    logic [DW-1:0] rd_val;

    // Control strobe decode from the clock state.
    always_comb begin
        in_cycle = (phase != PH_IDLE);
        strobe   = strobe_phase(phase);
        ale      = (phase == PH_T1);
        rd_n     = !(strobe && !q_wr);
        wr_n     = !(strobe && q_wr);
        den_n    = !strobe;
        dt_r     = in_cycle && q_wr;
        m_io     = in_cycle && q_mem;
    end

    // Shared bus: address in T1, write data in T2/T3, released otherwise.
    always_comb begin
        status = {{(AHI-2){1'b0}}, q_seg};
        ad_oe  = ale || (strobe && q_wr);
        if (ale)
            ad_o = q_addr[DW-1:0];
        else if (strobe && q_wr)
            ad_o = q_wlane;
        else
            ad_o = '0;
        if (ale)
            as_o = q_addr[AW-1:DW];
        else if (in_cycle)
            as_o = status;
        else
            as_o = '0;
        bhe_n = ale ? q_bhe_n : 1'b1;
    end

    // Read alignment: a word passes through, a byte moves to bits 7..0.
    always_comb begin
        if (q_word)
            rd_val = ad_i;
        else if (q_addr[0])
            rd_val = {{(DW-8){1'b0}}, ad_i[DW-1 -: 8]};
        else
            rd_val = {{(DW-8){1'b0}}, ad_i[7:0]};
    end

    // Read capture at the clock edge that ends T3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (phase == PH_T3 && !q_wr)
            rdata <= rd_val;
    end

    // R1: the address phase always drives the shared bus.
    p_ale_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    // R1: the latch strobe never lasts two clocks.
    p_ale_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R2: S7 is high whenever data is enabled.
    p_s7_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !den_n |-> bhe_n);

    // R3: the "no lane" code never shows up in an address phase.
    p_lane_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !(bhe_n && ad_o[0]));

    // R5: read and write strobes are never active together.
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R6: direction holds steady while data enable stays asserted.
    p_dir_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && !$past(den_n)) |-> (dt_r == $past(dt_r)));

endmodule

// File: rtl/mux_bus_cycle_ctrl.sv
// Module mux_bus_cycle_ctrl
// Top of the bus cycle controller. It stores an accepted request for the
// length of its bus cycle and ties together lane mapping, state stepping
// and pin driving.
// Assumes: AW > DW + 1 so that the upper lines can hold the status bits.
module mux_bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_word,
    input  logic          req_mem,
    input  logic [1:0]    req_seg,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_i,
    output logic [AW-DW-1:0] as_o,
    output logic          ale,
    output logic          bhe_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          m_io,
    output logic          den_n,
    output logic          dt_r
);
    bus_phase_t    phase;
    logic          accept;
    logic          misalign;
    logic          lane_bhe_n;
    logic [DW-1:0] lane_data;

    logic          q_wr, q_word, q_mem, q_bhe_n;
    logic [1:0]    q_seg;
    logic [AW-1:0] q_addr;
    logic [DW-1:0] q_wlane;

    bcc_lane_map #(.DW(DW)) u_lane (
        .word     (req_word),
        .a0       (req_addr[0]),
        .wdata    (req_wdata),
        .misalign (misalign),
        .bhe_n    (lane_bhe_n),
        .wlane    (lane_data)
    );

    bcc_phase_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_misalign (misalign),
        .phase        (phase),
        .accept       (accept),
        .ready        (ready),
        .done         (done),
        .err          (err)
    );

    // Request store: loaded on accept, held for the whole bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_wr    <= 1'b0;
            q_word  <= 1'b0;
            q_mem   <= 1'b0;
            q_bhe_n <= 1'b1;
            q_seg   <= '0;
            q_addr  <= '0;
            q_wlane <= '0;
        end else if (accept) begin
            q_wr    <= req_write;
            q_word  <= req_word;
            q_mem   <= req_mem;
            q_bhe_n <= lane_bhe_n;
            q_seg   <= req_seg;
            q_addr  <= req_addr;
            q_wlane <= lane_data;
        end
    end

    bcc_pin_drv #(.AW(AW), .DW(DW)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .q_wr    (q_wr),
        .q_word  (q_word),
        .q_mem   (q_mem),
        .q_seg   (q_seg),
        .q_addr  (q_addr),
        .q_bhe_n (q_bhe_n),
        .q_wlane (q_wlane),
        .ad_i    (ad_i),
        .ad_o    (ad_o),
        .ad_oe   (ad_oe),
        .as_o    (as_o),
        .ale     (ale),
        .bhe_n   (bhe_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .m_io    (m_io),
        .den_n   (den_n),
        .dt_r    (dt_r),
        .rdata   (rdata)
    );

    // R7: the space select holds steady for a running cycle once set.
    p_mio_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && !ready) |-> (m_io == $past(m_io)));

endmodule

// File: tb/sim_mux_bus_cycle_ctrl.sv
// Directed bench for mux_bus_cycle_ctrl: one task per scenario.
module sim_mux_bus_cycle_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_mem = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] ad_i = '0;
    logic        ready, done, err, ad_oe, ale, bhe_n, rd_n, wr_n, m_io, den_n, dt_r;
    logic [15:0] rdata, ad_o;
    logic [3:0]  as_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] last_rd = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_mem(req_mem), .req_seg(req_seg),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
        .err(err), .rdata(rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .as_o(as_o), .ale(ale), .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n),
        .m_io(m_io), .den_n(den_n), .dt_r(dt_r)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Runs one bus cycle; the caller stands just after a falling edge.
    // last=1 also checks the idle clock after T4.
    task automatic do_cycle(input logic wr, input logic word, input logic mem,
                            input logic [1:0] seg, input logic [19:0] addr,
                            input logic [15:0] wdata, input logic [15:0] rbus,
                            input logic [1:0] exp_lane, input logic [15:0] exp_wbus,
                            input logic [15:0] exp_rd, input bit last);
        req_valid = 1'b1; req_write = wr; req_word = word; req_mem = mem;
        req_seg = seg; req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        // T1
        chk("R1 ale in T1", ale, 1);
        chk("R1 ad_oe in T1", ad_oe, 1);
        chk("R1 low address", ad_o, addr[15:0]);
        chk("R1 high address", as_o, addr[19:16]);
        chk("R3 lane code", {bhe_n, ad_o[0]}, exp_lane);
        chk("R7 m_io T1", m_io, mem);
        chk("R6 dt_r T1", dt_r, wr);
        chk("R6 den_n T1", den_n, 1);
        chk("R10 ready low T1", ready, 0);
        @(negedge clk);
        ad_i = rbus;
        // T2 and T3
        for (int k = 0; k < 2; k++) begin
            chk("R1 ale low", ale, 0);
            chk("R2 status", as_o, {2'b00, seg});
            chk("R2 S7", bhe_n, 1);
            chk("R5 rd_n", rd_n, wr);
            chk("R5 wr_n", wr_n, !wr);
            chk("R6 den_n low", den_n, 0);
            chk("R6 dt_r", dt_r, wr);
            chk("R7 m_io", m_io, mem);
            chk("R8 ad_oe", ad_oe, wr);
            if (wr) chk("R8 write data", ad_o, exp_wbus);
            @(negedge clk);
        end
        // T4
        chk("R10 done T4", done, 1);
        chk("R10 ready T4", ready, 1);
        chk("R5 rd_n T4", rd_n, 1);
        chk("R5 wr_n T4", wr_n, 1);
        chk("R6 den_n T4", den_n, 1);
        chk("R6 dt_r T4", dt_r, wr);
        chk("R7 m_io T4", m_io, mem);
        chk("R8 released T4", ad_oe, 0);
        chk("R2 status T4", as_o, {2'b00, seg});
        chk("R9 rdata", rdata, exp_rd);
        if (!wr) last_rd = exp_rd;
        if (last) begin
            @(negedge clk);
            chk("R10 done low idle", done, 0);
            chk("R10 ale idle", ale, 0);
            chk("R6 dt_r idle", dt_r, 0);
            chk("R7 m_io idle", m_io, 0);
        end
    endtask

    task automatic t_reset;
        chk("R12 ale", ale, 0);
        chk("R12 rd_n", rd_n, 1);
        chk("R12 wr_n", wr_n, 1);
        chk("R12 den_n", den_n, 1);
        chk("R12 bhe_n", bhe_n, 1);
        chk("R12 dt_r", dt_r, 0);
        chk("R12 m_io", m_io, 0);
        chk("R12 ad_oe", ad_oe, 0);
        chk("R12 ready", ready, 1);
        chk("R12 done", done, 0);
        chk("R12 err", err, 0);
        chk("R12 rdata", rdata, 0);
    endtask

    task automatic t_word_read;   // R9 word read, memory space
        @(negedge clk);
        do_cycle(0, 1, 1, 2'd2, 20'h4A9C2, 16'h0000, 16'hBEEF, 2'b00, 16'h0, 16'hBEEF, 1);
    endtask

    task automatic t_byte_write_odd;  // R8 byte replicated, I/O space, rdata held (R9)
        @(negedge clk);
        do_cycle(1, 0, 0, 2'd1, 20'h00371, 16'h775A, 16'h0000, 2'b01, 16'h5A5A, last_rd, 1);
    endtask

    task automatic t_byte_reads;  // R9 even and odd lane alignment
        @(negedge clk);
        do_cycle(0, 0, 1, 2'd0, 20'hF0010, 16'h0, 16'h1234, 2'b10, 16'h0, 16'h0034, 1);
        @(negedge clk);
        do_cycle(0, 0, 1, 2'd3, 20'hF0011, 16'h0, 16'h1234, 2'b01, 16'h0, 16'h0012, 1);
    endtask

    task automatic t_word_write;  // R8 full word on the bus
        @(negedge clk);
        do_cycle(1, 1, 1, 2'd3, 20'h8BCD4, 16'hC3A5, 16'h0000, 2'b00, 16'hC3A5, last_rd, 1);
    endtask

    task automatic t_misaligned;  // R4 refused word at odd address
        @(negedge clk);
        req_valid = 1; req_write = 0; req_word = 1; req_mem = 1; req_addr = 20'h12345;
        @(negedge clk);
        req_valid = 0;
        chk("R4 err pulse", err, 1);
        chk("R4 no ale", ale, 0);
        chk("R4 no rd", rd_n, 1);
        chk("R4 ready", ready, 1);
        @(negedge clk);
        chk("R4 err one cycle", err, 0);
        chk("R4 still no ale", ale, 0);
        chk("R4 no done", done, 0);
    endtask

    task automatic t_back_to_back;  // R10 done and next request in one cycle
        @(negedge clk);
        do_cycle(0, 1, 1, 2'd1, 20'h30A0E, 16'h0, 16'h6C6C, 2'b00, 16'h0, 16'h6C6C, 0);
        do_cycle(1, 0, 1, 2'd2, 20'h30A0F, 16'h0099, 16'h0, 2'b01, 16'h9999, 16'h6C6C, 0);
        // refused request in T4: back to idle with err
        req_valid = 1; req_write = 0; req_word = 1; req_addr = 20'h00001;
        @(negedge clk);
        req_valid = 0;
        chk("R4 err after T4", err, 1);
        chk("R4 no ale after T4", ale, 0);
        chk("R10 idle after refuse", done, 0);
    endtask

    task automatic t_ignored;  // R11 request while busy has no effect
        @(negedge clk);
        req_valid = 1; req_write = 1; req_word = 1; req_mem = 0; req_seg = 2'd0;
        req_addr = 20'h05550; req_wdata = 16'h1111;
        @(negedge clk);
        req_valid = 0;
        chk("R11 T1 addr", ad_o, 16'h5550);
        @(negedge clk);
        req_valid = 1; req_addr = 20'hAAAA0; req_wdata = 16'h2222; req_write = 0; req_mem = 1;
        @(negedge clk);
        chk("R11 T3 data kept", ad_o, 16'h1111);
        chk("R11 T3 still write", wr_n, 0);
        chk("R11 T3 space kept", m_io, 0);
        chk("R11 no new ale", ale, 0);
        req_valid = 0;
        @(negedge clk);
        chk("R11 T4 done", done, 1);
        @(negedge clk);
        chk("R11 idle, no ale", ale, 0);
        chk("R11 idle ready", ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_read();
        t_byte_write_odd();
        t_byte_reads();
        t_word_write();
        t_misaligned();
        t_back_to_back();
        t_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule